// File: doc/BRIEF.md
# Paired-Halfword Settings Write Bridge

This bridge sits on a 16-bit, byte-addressed peripheral bus and turns pairs of halfword writes into single 32-bit setting updates. The settings space holds a parameterised number of registers (32 by default) with a four-byte stride. Software writes the lower halfword of a register first, at the word-aligned offset. It then writes the upper halfword at the offset two bytes higher. Only that second, completing write produces an update on the output side.

The output is a write-only settings strobe interface: a register index, a 32-bit value and a strobe that is high for one cycle. The downstream consumers latch the value when they see the strobe. The bus side acknowledges every access one cycle after the request. Reads are acknowledged and return zero, because no register contents are held for readback.

Top module: `setbus_bridge`

## Requirements
- R1: A request's byte address is decoded as follows. Bit 1 selects the half: 0 is the lower halfword and 1 is the upper halfword. Bits [IDX_W+1:2] give the register index. Bit 0 is ignored.
- R2: A write with address bit 1 = 0 stores its data as the pending lower halfword for its index. It produces no strobe.
- R3: A write with address bit 1 = 1 whose index matches the pending lower halfword produces exactly one set_stb pulse. The pulse comes in the cycle after the request. In that cycle set_addr equals the index and set_data equals {upper write data, pending lower data}.
- R4: A write with address bit 1 = 1 produces no strobe when no lower halfword is pending, or when the pending index differs. In both cases it discards any pending lower halfword.
- R5: A second lower-halfword write before the completing write replaces the pending data and index. The latest one wins.
- R6: After a strobe, nothing is pending. A repeated upper-halfword write without a new lower write produces no strobe.
- R7: Every request is acknowledged with resp_ack high exactly in the following cycle, and resp_ack is low otherwise. Reads return resp_rdata = 0 and leave any pending lower halfword intact.
- R8: set_stb never stays high for two consecutive cycles. set_addr and set_data hold their values between strobes.
- R9: While rst is high and after reset: resp_ack, set_stb, set_addr and set_data are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | IDX_W+2 (7) | Byte address within the settings region |
| req_wdata | input | HALF_W (16) | Write halfword |
| resp_ack | output | 1 | Access acknowledge, one cycle after the request |
| resp_rdata | output | HALF_W (16) | Read data, always zero |
| set_stb | output | 1 | One-cycle setting write strobe |
| set_addr | output | IDX_W (5) | Register index of the setting write |
| set_data | output | 2*HALF_W (32) | 32-bit setting value |

## Verification
The bench pairs every one of the 32 indices, with data derived from the index, so a bridge that swapped halves or sliced the index from the wrong address bits would produce wrong values. Orphan upper writes, mismatched indices, a replaced lower half, and a repeated upper write are each driven; a bridge that strobed on any of these would emit a spurious update. Reads are placed between the halves of a pair to catch a read that disturbed the pending state. Address bit 0 is set on some writes to catch a decoder that used it.

// File: rtl/setbus_pkg.sv
package setbus_pkg;

    localparam int HALF_W_DFLT   = 16;
    localparam int NUM_REGS_DFLT = 32;

    // Decoded kind of a bus request for the current cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_LOW  = 2'd2,
        OP_HIGH = 2'd3
    } op_e;

    // Address bit 1 chooses the half; bit 0 is never consulted.
    function automatic op_e classify(input logic valid, input logic we, input logic half_sel);
        if (!valid)
            return OP_IDLE;
        else if (!we)
            return OP_READ;
        else if (half_sel)
            return OP_HIGH;
        else
            return OP_LOW;
    endfunction

endpackage

// File: rtl/setbus_front.sv
module setbus_front
    import setbus_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int HALF_W = 16,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    output op_e               op,
    output logic [IDX_W-1:0]  idx,
    output logic              resp_ack,
    output logic [HALF_W-1:0] resp_rdata
);

    assign op  = classify(req_valid, req_we, req_addr[1]);
    assign idx = req_addr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst)
            resp_ack <= 1'b0;
        else
            resp_ack <= req_valid;
    end

    // No readback storage: reads complete with zero.
    assign resp_rdata = '0;

    p_ack_follows_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_ack);
    p_no_spurious_ack_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_ack);

endmodule

// File: rtl/setbus_pair.sv
module setbus_pair
    import setbus_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int HALF_W = 16,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [HALF_W-1:0] wdata,
    output logic              fire,
    output logic [IDX_W-1:0]  fire_idx,
    output logic [DATA_W-1:0] fire_data
);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [HALF_W-1:0] low;
    } pending_t;

    pending_t pend;

    assign fire      = (op == OP_HIGH) && pend.valid && (pend.idx == idx);
    assign fire_idx  = idx;
    assign fire_data = {wdata, pend.low};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            unique case (op)
                OP_LOW:  pend <= '{valid: 1'b1, idx: idx, low: wdata};
                OP_HIGH: pend.valid <= 1'b0;
                default: pend <= pend;
            endcase
        end
    end

    p_low_arms_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOW) |=> pend.valid);
    p_high_disarms_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HIGH) |=> !pend.valid);
    p_read_keeps_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> ($stable(pend.valid) && $stable(pend.idx) && $stable(pend.low)));

endmodule

// File: rtl/setbus_out.sv
module setbus_out #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [IDX_W-1:0]  fire_idx,
    input  logic [DATA_W-1:0] fire_data,
    output logic              set_stb,
    output logic [IDX_W-1:0]  set_addr,
    output logic [DATA_W-1:0] set_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            set_stb  <= 1'b0;
            set_addr <= '0;
            set_data <= '0;
        end else begin
            set_stb <= fire;
            if (fire) begin
                set_addr <= fire_idx;
                set_data <= fire_data;
            end
        end
    end

    p_stb_single_r8: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> !set_stb);
    p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
        !set_stb |-> ($stable(set_addr) && $stable(set_data)));

endmodule

// File: rtl/setbus_bridge.sv
module setbus_bridge
    import setbus_pkg::*;
#(
    parameter int NUM_REGS = NUM_REGS_DFLT,
    parameter int HALF_W   = HALF_W_DFLT,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int ADDR_W  = IDX_W + 2,
    localparam int DATA_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HALF_W-1:0] req_wdata,
    output logic              resp_ack,
    output logic [HALF_W-1:0] resp_rdata,
    output logic              set_stb,
    output logic [IDX_W-1:0]  set_addr,
    output logic [DATA_W-1:0] set_data
);

    op_e               op;
    logic [IDX_W-1:0]  idx;
    logic              fire;
    logic [IDX_W-1:0]  fire_idx;
    logic [DATA_W-1:0] fire_data;

    setbus_front #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_front (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .op(op), .idx(idx),
        .resp_ack(resp_ack), .resp_rdata(resp_rdata)
    );

    setbus_pair #(.IDX_W(IDX_W), .HALF_W(HALF_W)) u_pair (
        .clk(clk), .rst(rst), .op(op), .idx(idx), .wdata(req_wdata),
        .fire(fire), .fire_idx(fire_idx), .fire_data(fire_data)
    );

    setbus_out #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .fire(fire), .fire_idx(fire_idx), .fire_data(fire_data),
        .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data)
    );

    p_stb_from_upper_write_r3: assert property (@(posedge clk) disable iff (rst)
        set_stb |-> $past(req_valid && req_we && req_addr[1]));
    p_stb_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
        set_stb |-> resp_ack);

endmodule

// File: tb/tb_setbus_bridge.sv
module tb_setbus_bridge;

    localparam int NUM_REGS = 32;
    localparam int HALF_W   = 16;
    localparam int IDX_W    = 5;
    localparam int ADDR_W   = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [HALF_W-1:0] req_wdata = '0;
    logic              resp_ack;
    logic [HALF_W-1:0] resp_rdata;
    logic              set_stb;
    logic [IDX_W-1:0]  set_addr;
    logic [31:0]       set_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench-side model of the pending lower half and last emitted setting.
    bit          m_pv = 1'b0;
    int          m_pidx = 0;
    logic [15:0] m_plo = '0;
    logic [4:0]  m_lastaddr = '0;
    logic [31:0] m_lastdata = '0;

    always #2 clk = ~clk;

    setbus_bridge #(.NUM_REGS(NUM_REGS), .HALF_W(HALF_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_ack(resp_ack),
        .resp_rdata(resp_rdata), .set_stb(set_stb), .set_addr(set_addr),
        .set_data(set_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request: driven at negedge, captured at posedge, results sampled at next negedge.
    task automatic access(input bit we, input int index, input bit upper, input bit b0,
                          input logic [15:0] data, input string req);
        bit exp_stb;
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = ADDR_W'((index << 2) | (int'(upper) << 1) | int'(b0));
        req_wdata = data;
        exp_stb = 1'b0;
        if (we && !upper) begin
            m_pv = 1'b1; m_pidx = index; m_plo = data;
        end else if (we && upper) begin
            if (m_pv && m_pidx == index) begin
                exp_stb = 1'b1;
                m_lastaddr = 5'(index);
                m_lastdata = {data, m_plo};
            end
            m_pv = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " ack (R7)"}, 32'(resp_ack), 32'd1);
        if (!we) check({req, " rdata (R7)"}, 32'(resp_rdata), 32'd0);
        check({req, " stb"}, 32'(set_stb), 32'(exp_stb));
        check({req, " set_addr"}, 32'(set_addr), 32'(m_lastaddr));
        check({req, " set_data"}, set_data, m_lastdata);
        // Idle cycle: no ack, strobe gone, outputs held (R8).
        @(negedge clk);
        check({req, " idle ack (R7)"}, 32'(resp_ack), 32'd0);
        check({req, " idle stb (R8)"}, 32'(set_stb), 32'd0);
        check({req, " idle data (R8)"}, set_data, m_lastdata);
    endtask

    function automatic logic [15:0] lo_of(input int i);
        return 16'((i * 16'h0101) ^ 16'h5A5A);
    endfunction

    function automatic logic [15:0] hi_of(input int i);
        return 16'((i * 16'h0B07) ^ 16'hC3A5);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("reset ack (R9)", 32'(resp_ack), 32'd0);
        check("reset stb (R9)", 32'(set_stb), 32'd0);
        check("reset addr (R9)", 32'(set_addr), 32'd0);
        check("reset data (R9)", set_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R4/R9: an upper write straight after reset finds nothing pending
        access(1, 3, 1, 0, 16'hDEAD, "orphan after reset (R4 R9)");

        // R1 R2 R3: sweep of every index in pairs, bit 0 set on odd indices
        for (int i = 0; i < NUM_REGS; i++) begin
            access(1, i, 0, i[0], lo_of(i), "sweep lower (R2 R1)");
            access(1, i, 1, i[0], hi_of(i), "sweep upper (R3 R1)");
        end

        // R6: repeated upper write after a completed pair
        access(1, 9, 0, 0, 16'h1111, "pair lower (R2)");
        access(1, 9, 1, 0, 16'h2222, "pair upper (R3)");
        access(1, 9, 1, 0, 16'h3333, "repeat upper (R6)");

        // R4: mismatched index discards the pending half
        access(1, 4, 0, 0, 16'hAAAA, "lower idx4 (R2)");
        access(1, 5, 1, 0, 16'hBBBB, "upper idx5 mismatch (R4)");
        access(1, 4, 1, 0, 16'hCCCC, "upper idx4 after discard (R4)");

        // R5: the newer lower write replaces data and index
        access(1, 7, 0, 0, 16'h0707, "lower idx7 (R5)");
        access(1, 12, 0, 0, 16'h1212, "lower idx12 (R5)");
        access(1, 7, 1, 0, 16'hF7F7, "upper idx7 stale (R5)");
        access(1, 12, 0, 0, 16'h3434, "lower idx12 again (R5)");
        access(1, 12, 1, 0, 16'hF1F1, "upper idx12 (R5)");

        // R7: reads between halves return zero and keep the pending half
        access(1, 31, 0, 0, 16'h8001, "lower idx31 (R7)");
        access(0, 31, 0, 0, 16'hFFFF, "read lower slot (R7)");
        access(0, 31, 1, 0, 16'hFFFF, "read upper slot (R7)");
        access(1, 31, 1, 0, 16'h7FFE, "upper idx31 after reads (R7)");

        // R1: bit 0 on the upper write is ignored
        access(1, 0, 0, 0, 16'h0F0F, "lower idx0 (R1)");
        access(1, 0, 1, 1, 16'hF0F0, "upper idx0 bit0 set (R1)");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule